// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing half of a byte-wide serial memory of up to 32K locations. It watches the two-wire clock and data lines through synchronizers running on the system clock, finds start and stop conditions, and shifts bytes in and out MSB first. The engine acknowledges a byte by pulling the data line low through an open-drain enable. It never drives the line high.

A transaction begins with a selection byte. That byte holds a fixed four-bit type code, three bits that must equal the strap inputs, and a direction bit. A write transaction then carries two memory-address bytes, high byte first, followed by data bytes. Each data byte goes to a page-write controller together with its address, and the address counter steps after every byte. A stop that lands on a byte boundary after at least one data byte raises a commit pulse.

A read transaction has no address phase. It streams bytes from the current address counter through a synchronous memory read port with one cycle of latency, and it keeps going while the master acknowledges. While the controller reports an internal write in progress, the engine acknowledges nothing, so the master can poll the selection byte until the write completes.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset the engine does not pull the data line (sda_oe = 0) and raises neither wr_vld, wr_commit nor rd_en.
- R2: A selection byte whose bits 7..1 equal 1010 followed by strap[2:0] (bit 0: 1 = read, 0 = write) is acknowledged. If bits 3..1 differ from the straps, the byte is not acknowledged, and no later byte before the next start is acknowledged or forwarded.
- R3: A selection byte whose bits 7..4 are not 1010 is not acknowledged.
- R4: In a write, the two bytes after the selection byte load the address counter, high byte first. Each further byte is acknowledged and appears on wr_data with its address on wr_addr for one cycle (wr_vld), and the counter steps by one after every data byte, carrying across byte boundaries.
- R5: Bit 7 of the high address byte is ignored, and bits 6..0 become address bits 14..8. With MEM_AW = 14, bit 6 is ignored as well.
- R6: wr_commit pulses for one cycle when a stop ends a write at a byte boundary after at least one data byte. A stop in the middle of a byte, or a stop after the address bytes alone, gives no pulse.
- R7: A read selection byte starts a stream from the current counter. Bits are sampled on rising SCL and changed after falling SCL. Each byte sent steps the counter, and the next byte follows while the master acknowledges.
- R8: When the master does not acknowledge a read byte, the engine releases the line and ignores the bus until a stop or start. A later read resumes at the address after the last byte sent.
- R9: While busy_i is high, no byte is acknowledged (the selection byte included), and no data is forwarded.
- R10: A start inside any byte abandons the transaction, and the next byte is taken as a fresh selection byte.
- R11: sda_oe is asserted only after a falling SCL and is released after the falling SCL that ends each acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap | input | 3 | Selection bits compared against bits 3..1 of the first byte |
| busy_i | input | 1 | Internal write in progress |
| wr_vld | output | 1 | One-cycle strobe for a received data byte |
| wr_addr | output | MEM_AW | Address of the forwarded data byte |
| wr_data | output | 8 | Forwarded data byte |
| wr_commit | output | 1 | Stop ended a write at a byte boundary |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | MEM_AW | Memory read address (current counter) |
| rd_data | input | 8 | Read data, valid the cycle after rd_en |

## Verification
A write whose address starts two below a 256-byte boundary, with the high address byte's top bit set, checks the counter carry and the ignored bit together. Current-address reads that follow it are ended by a master no-acknowledge, and then a second read is issued. Comparing the first bytes of both reads against the memory model separates incrementing per byte sent from incrementing per master acknowledge. Selection bytes with a wrong strap, a wrong type code, or an asserted busy separate the three reasons for staying silent. Stops in mid-byte and after the address alone, together with a start inserted mid-byte, separate the commit rule and the abort path from normal framing.

// File: rtl/sms_pkg.sv
package sms_pkg;
  localparam logic [3:0] TYPE_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_SKIP
  } eng_st_t;
endpackage

// File: rtl/sms_line_sync.sv
module sms_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] cur,
  output logic [LINES-1:0] prev
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-1:0], raw[g]};
    end
    assign cur[g]  = chain[STAGES-1];
    assign prev[g] = chain[STAGES];
  end
endmodule

// File: rtl/sms_addr_ctr.sv
module sms_addr_ctr #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] cur
);
  logic [AW-1:0] cur_n;

  always_comb begin
    cur_n = cur;
    if (load)     cur_n = load_val;
    else if (inc) cur_n = cur + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cur <= '0;
    else if (load || inc)  cur <= cur_n;
  end
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
  import sms_pkg::*;
#(
  parameter int MEM_AW = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        strap,
  input  logic              busy_i,
  output logic              wr_vld,
  output logic [MEM_AW-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  output logic              rd_en,
  output logic [MEM_AW-1:0] rd_addr,
  input  logic [7:0]        rd_data
);
  localparam int HI_W = 7;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sh;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_l = rst_sh[1];

  logic [1:0] ln_cur, ln_prev;
  sms_line_sync #(.LINES(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_l), .raw({scl_i, sda_i}),
    .cur(ln_cur), .prev(ln_prev)
  );

  logic scl_s, scl_q, sda_s, sda_q;
  assign {scl_s, sda_s} = ln_cur;
  assign {scl_q, sda_q} = ln_prev;

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  eng_st_t             st, st_n;
  logic [3:0]          bitcnt, bitcnt_n;
  logic                in_ack, in_ack_n;
  logic [7:0]          sh, sh_n, tx, tx_n, wd_n;
  logic [HI_W-1:0]     hi, hi_n;
  logic                oe_n, mack, mack_n, got, got_n;
  logic                rd_req, rd_pend, wv_n, cm_n;
  logic                ld, inc;
  logic [MEM_AW-1:0]   cur, wa_n;
  logic [HI_W+7:0]     full_addr;

  assign full_addr = {hi, sh};

  sms_addr_ctr #(.AW(MEM_AW)) u_ctr (
    .clk(clk), .rst_n(rst_l), .load(ld), .load_val(full_addr[MEM_AW-1:0]),
    .inc(inc), .cur(cur)
  );
  assign rd_addr = cur;

  always_comb begin
    st_n = st;  bitcnt_n = bitcnt;  in_ack_n = in_ack;
    sh_n = sh;  hi_n = hi;  oe_n = sda_oe;  mack_n = mack;  got_n = got;
    tx_n = rd_pend ? rd_data : tx;
    wd_n = wr_data;  wa_n = wr_addr;
    wv_n = 1'b0;  cm_n = 1'b0;  rd_req = 1'b0;  ld = 1'b0;  inc = 1'b0;
    if (start_c) begin
      st_n = ST_SEL;  bitcnt_n = '0;  in_ack_n = 1'b0;  oe_n = 1'b0;
    end else if (stop_c) begin
      if (st == ST_WDAT && bitcnt <= 4'd1 && !in_ack && got) cm_n = 1'b1;
      st_n = ST_IDLE;  bitcnt_n = '0;  in_ack_n = 1'b0;  oe_n = 1'b0;
    end else if (st != ST_IDLE && st != ST_SKIP) begin
      if (scl_rise) begin
        if (in_ack) begin
          mack_n = ~sda_s;
          if (st == ST_RDAT && !sda_s) rd_req = 1'b1;
        end else begin
          sh_n = {sh[6:0], sda_s};
          if (bitcnt < 4'd8) bitcnt_n = bitcnt + 4'd1;
        end
      end
      if (scl_fall) begin
        if (!in_ack && bitcnt == 4'd8) begin
          in_ack_n = 1'b1;
          if (st == ST_RDAT) begin
            oe_n = 1'b0;
            inc  = 1'b1;
          end else if (busy_i ||
                       (st == ST_SEL && sh[7:1] != {TYPE_CODE, strap})) begin
            st_n = ST_SKIP;  in_ack_n = 1'b0;
          end else begin
            oe_n = 1'b1;
            unique case (st)
              ST_SEL:  if (sh[0]) begin st_n = ST_RDAT; rd_req = 1'b1; end
                       else st_n = ST_AHI;
              ST_AHI:  begin hi_n = sh[HI_W-1:0]; st_n = ST_ALO; end
              ST_ALO:  begin ld = 1'b1; got_n = 1'b0; st_n = ST_WDAT; end
              default: begin
                wv_n = 1'b1;  wd_n = sh;  wa_n = cur;  inc = 1'b1;  got_n = 1'b1;
              end
            endcase
          end
        end else if (in_ack) begin
          in_ack_n = 1'b0;  bitcnt_n = '0;  oe_n = 1'b0;
          if (st == ST_RDAT) begin
            if (mack) oe_n = ~tx[7];
            else      st_n = ST_SKIP;
          end
        end else if (st == ST_RDAT && bitcnt != 4'd0) begin
          oe_n = ~tx[3'd7 - bitcnt[2:0]];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      st <= ST_IDLE;  bitcnt <= '0;  in_ack <= 1'b0;  sh <= '0;  tx <= '0;
      hi <= '0;  sda_oe <= 1'b0;  mack <= 1'b0;  got <= 1'b0;
      rd_en <= 1'b0;  rd_pend <= 1'b0;  wr_vld <= 1'b0;  wr_commit <= 1'b0;
      wr_data <= '0;  wr_addr <= '0;
    end else begin
      st <= st_n;  bitcnt <= bitcnt_n;  in_ack <= in_ack_n;  sh <= sh_n;
      tx <= tx_n;  hi <= hi_n;  sda_oe <= oe_n;  mack <= mack_n;  got <= got_n;
      rd_en <= rd_req;  rd_pend <= rd_en;  wr_vld <= wv_n;  wr_commit <= cm_n;
      if (wv_n) begin
        wr_data <= wd_n;
        wr_addr <= wa_n;
      end
    end
  end
endmodule

// File: rtl/sms_checker.sv
module sms_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic busy_i,
  input logic wr_vld,
  input logic wr_commit,
  input logic rd_en
);
  // R4: each forwarded data byte is a single-cycle strobe
  a_r4_wr_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |=> !wr_vld);

  // R9: nothing is forwarded when busy was seen at the byte decision
  a_r9_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |-> !$past(busy_i));

  // R6: commit is a single-cycle pulse
  a_r6_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);

  // R11: the line is pulled only while the clock is low
  a_r11_pull_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  // R7: a read request lasts one cycle
  a_r7_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);

  // R6: a commit never coincides with a data strobe
  a_r6_commit_apart: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> !wr_vld);
endmodule

bind serial_mem_slave sms_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .busy_i(busy_i),
  .wr_vld(wr_vld), .wr_commit(wr_commit), .rd_en(rd_en)
);

// File: tb/sim_serial_mem_slave.sv
module sim_serial_mem_slave;
  localparam int AW = 15;
  localparam int Q  = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, scl_m, sda_m, busy;
  logic [2:0]    strap;
  logic          sda_oe, wr_vld, wr_commit, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data;
  wire           sda_line = sda_m & ~sda_oe;

  serial_mem_slave #(.MEM_AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap(strap), .busy_i(busy), .wr_vld(wr_vld), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_commit(wr_commit), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] mem_f(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) if (rd_en) rd_data <= mem_f(rd_addr);

  int nchk = 0, nbad = 0, ncommit = 0;
  bit done = 1'b0;
  logic [22:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected write items as the design forwards them
  always @(negedge clk) begin
    if (rst_n && wr_commit) ncommit++;
    if (rst_n && wr_vld) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected write", int'({wr_addr, wr_data}), 0);
      else begin
        logic [22:0] e;
        e = exp_q.pop_front();
        chk({wr_addr, wr_data} == e, "R4 write item", int'({wr_addr, wr_data}), int'(e));
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = ~sda_line;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = ~give_ack; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic send_expect(input logic [7:0] b, input logic exp_ack, input string req);
    logic a;
    put_byte(b, a);
    chk(a == exp_ack, req, int'(a), int'(exp_ack));
  endtask

  task automatic read_expect(input logic [14:0] a, input logic give_ack, input string req);
    logic [7:0] d;
    get_byte(give_ack, d);
    chk(d == mem_f(a), req, int'(d), int'(mem_f(a)));
  endtask

  localparam logic [7:0] SEL_W = 8'b1010_101_0;
  localparam logic [7:0] SEL_R = 8'b1010_101_1;

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; busy = 1'b0; strap = 3'b101;
    tick(5);
    chk(!sda_oe && !wr_vld && !wr_commit && !rd_en, "R1 reset outputs",
        int'({sda_oe, wr_vld, wr_commit, rd_en}), 0);
    rst_n = 1'b1; tick(10);

    // R4/R5: top bit of high byte ignored, counter carries across 0x43FF
    exp_q.push_back({15'h43FE, 8'h11});
    exp_q.push_back({15'h43FF, 8'h22});
    exp_q.push_back({15'h4400, 8'h33});
    bus_start();
    send_expect(SEL_W, 1'b1, "R2 matching selection ack");
    send_expect(8'hC3, 1'b1, "R4 high address ack");
    send_expect(8'hFE, 1'b1, "R4 low address ack");
    send_expect(8'h11, 1'b1, "R4 data ack");
    chk(!sda_oe, "R11 released after ack", int'(sda_oe), 0);
    send_expect(8'h22, 1'b1, "R4 data ack");
    send_expect(8'h33, 1'b1, "R5 data ack");
    bus_stop();
    chk(ncommit == 1, "R6 commit after data", ncommit, 1);

    // R7/R8: current-address read stream ending in no-acknowledge
    bus_start();
    send_expect(SEL_R, 1'b1, "R7 read selection ack");
    read_expect(15'h4401, 1'b1, "R7 first read byte");
    read_expect(15'h4402, 1'b1, "R7 streamed byte");
    read_expect(15'h4403, 1'b0, "R8 last byte before nack");
    chk(!sda_oe, "R8 line released after nack", int'(sda_oe), 0);
    bus_stop();
    bus_start();
    send_expect(SEL_R, 1'b1, "R8 second read ack");
    read_expect(15'h4404, 1'b0, "R8 resumes after last byte");
    bus_stop();

    // R2/R3: wrong strap and wrong type code
    bus_start();
    send_expect(8'b1010_100_0, 1'b0, "R2 strap mismatch nack");
    send_expect(8'h00, 1'b0, "R2 later byte ignored");
    bus_stop();
    bus_start();
    send_expect(8'b1001_101_0, 1'b0, "R3 type mismatch nack");
    bus_stop();

    // R9: busy silences everything
    busy = 1'b1;
    bus_start();
    send_expect(SEL_W, 1'b0, "R9 busy write selection nack");
    send_expect(8'h00, 1'b0, "R9 busy further byte nack");
    bus_stop();
    bus_start();
    send_expect(SEL_R, 1'b0, "R9 busy read selection nack");
    bus_stop();
    busy = 1'b0;

    // R6: stop in mid-byte gives no commit
    exp_q.push_back({15'h0010, 8'hAA});
    bus_start();
    send_expect(SEL_W, 1'b1, "R6 selection ack");
    send_expect(8'h00, 1'b1, "R6 high ack");
    send_expect(8'h10, 1'b1, "R6 low ack");
    send_expect(8'hAA, 1'b1, "R6 data ack");
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    chk(ncommit == 1, "R6 no commit on mid-byte stop", ncommit, 1);

    // R10: start inside a byte restarts selection
    exp_q.push_back({15'h0120, 8'h5C});
    bus_start();
    send_expect(SEL_W, 1'b1, "R10 selection ack");
    send_expect(8'h00, 1'b1, "R10 high ack");
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    bus_start();
    send_expect(SEL_W, 1'b1, "R10 selection after restart");
    send_expect(8'h01, 1'b1, "R10 high ack");
    send_expect(8'h20, 1'b1, "R10 low ack");
    send_expect(8'h5C, 1'b1, "R10 data ack");
    bus_stop();
    chk(ncommit == 2, "R6 commit after restarted write", ncommit, 2);

    // R6: address-only write, then read from the loaded address
    bus_start();
    send_expect(SEL_W, 1'b1, "R6 selection ack");
    send_expect(8'h02, 1'b1, "R6 high ack");
    send_expect(8'h00, 1'b1, "R6 low ack");
    bus_stop();
    chk(ncommit == 2, "R6 no commit without data", ncommit, 2);
    bus_start();
    send_expect(SEL_R, 1'b1, "R4 read selection ack");
    read_expect(15'h0200, 1'b0, "R4 read at loaded address");
    bus_stop();

    tick(20);
    chk(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule